// File: doc/BRIEF.md
# Power-up strap capture and configuration holder

This block gives a PHY its identity and its first configuration. The board ties a small set of address pins and mode pins high or low. When hardware reset is released, the block copies those levels into registers on the first clock edge. From then on the copy is the PHY's management address and the starting value of its configuration bits. The pins themselves are ignored until the next hardware reset, even if they move.

The held address has three uses:
- It is compared against the address field of every incoming management frame. A registered match flag tells the frame logic whether to answer.
- It is widened into the scrambler seed, so that PHYs sharing a board start their scramblers at different points.
- It stays fixed while the PHY runs.

The configuration bits can be rewritten later through the register path. A software-requested soft reset runs a fixed-length reinitialisation window and then clears its own request bit. The soft reset leaves the held address and the configuration register as they are, and it does not read the pins again.

Top module: `strap_cfg_ctl`

## Requirements
- R1: While `rst_n` is low, `strap_done`, `phy_addr`, `cfg_bits`, `soft_rst` and `addr_match` are all 0.
- R2: On the first rising clock edge with `rst_n` high, `phy_addr` takes `strap_addr`, `cfg_bits` takes `strap_mode` and `strap_done` becomes 1. A configuration write or soft-reset request on that same edge is ignored.
- R3: After capture, changes on `strap_addr` and `strap_mode` have no effect until `rst_n` is pulsed low again. The next release then captures the new pin levels.
- R4: `scram_seed` is `phy_addr` in its low ADDR_W bits, with every bit above set to 1.
- R5: `addr_match` is 1 in the cycle after a cycle where `frame_vld` is 1 and `frame_addr` equals `phy_addr`. It is 0 otherwise, including for a frame addressed to 0 when `phy_addr` is not 0.
- R6: After capture, `cfg_wr_en` loads `cfg_wr_data` into `cfg_bits` on the next edge.
- R7: After capture, a `srst_req` pulse raises `soft_rst` on the next edge. `soft_rst` stays high for exactly REINIT_CYCLES cycles and then clears by itself. Requests made while it is high neither restart nor extend the window.
- R8: A soft reset leaves `phy_addr` and `cfg_bits` unchanged. The strap pins are not sampled again, even when their levels differ from the held values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous assert |
| strap_addr | input | ADDR_W | Address strap pins |
| strap_mode | input | MODE_W | Mode strap pins |
| cfg_wr_en | input | 1 | Write strobe for the configuration bits |
| cfg_wr_data | input | MODE_W | New configuration value |
| srst_req | input | 1 | Soft-reset bit being set by software |
| frame_vld | input | 1 | A management frame address field is present |
| frame_addr | input | ADDR_W | Address field of that frame |
| strap_done | output | 1 | Straps have been captured |
| phy_addr | output | ADDR_W | Held PHY address |
| scram_seed | output | SEED_W | Scrambler seed derived from the address |
| cfg_bits | output | MODE_W | Configuration register bits |
| soft_rst | output | 1 | Soft-reset bit, high during reinitialisation |
| addr_match | output | 1 | Registered frame address match |

## Verification
The hardest case to reach is the capture edge itself. The stimulus releases `rst_n` while a configuration write and a soft-reset request are already being driven, so the capture has to win over both on that one edge.

A second hard case is the soft-reset window. The bench moves the strap pins to new levels before the soft reset and sends a second request in the middle of the window. It then checks two things: the window still closes after exactly REINIT_CYCLES cycles, and the held address and configuration keep their old values.

A second hardware reset with an all-zero address confirms that the pins are captured again. That capture is followed by a frame addressed to zero.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;
    // Phase of the soft-reset sequencer
    typedef enum logic {
        SR_IDLE = 1'b0,
        SR_BUSY = 1'b1
    } srst_phase_e;

    // Value used to fill seed bits above the address field
    localparam logic SEED_FILL_BIT = 1'b1;
endpackage

// File: rtl/strap_cfg_capture.sv
module strap_cfg_capture #(
    parameter int ADDR_W = 5,
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic [MODE_W-1:0] strap_mode,
    input  logic              cfg_wr_en,
    input  logic [MODE_W-1:0] cfg_wr_data,
    output logic              done,
    output logic [ADDR_W-1:0] addr,
    output logic [MODE_W-1:0] cfg
);
    typedef struct packed {
        logic              done;
        logic [ADDR_W-1:0] addr;
        logic [MODE_W-1:0] cfg;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.done) begin
            // first edge after reset release: pins win over everything
            st_d.done = 1'b1;
            st_d.addr = strap_addr;
            st_d.cfg  = strap_mode;
        end else if (cfg_wr_en) begin
            st_d.cfg  = cfg_wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done = st_q.done;
    assign addr = st_q.addr;
    assign cfg  = st_q.cfg;
endmodule

// File: rtl/strap_cfg_match.sv
module strap_cfg_match #(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              frame_vld,
    input  logic [ADDR_W-1:0] frame_addr,
    output logic              hit
);
    typedef struct packed {
        logic hit;
    } match_state_t;

    match_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.hit = done && frame_vld && (frame_addr == own_addr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit = st_q.hit;
endmodule

// File: rtl/strap_cfg_softrst.sv
module strap_cfg_softrst
    import strap_cfg_pkg::*;
#(
    parameter int REINIT_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  logic req,
    output logic busy
);
    localparam int CNT_W = (REINIT_CYCLES > 2) ? $clog2(REINIT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(REINIT_CYCLES - 1);

    typedef struct packed {
        srst_phase_e      phase;
        logic [CNT_W-1:0] cnt;
    } sr_state_t;

    sr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            SR_IDLE: begin
                // a request on the capture edge is dropped
                if (done && req) begin
                    st_d.phase = SR_BUSY;
                    st_d.cnt   = '0;
                end
            end
            SR_BUSY: begin
                if (st_q.cnt == LAST) begin
                    st_d.phase = SR_IDLE;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.phase == SR_BUSY);
endmodule

// File: rtl/strap_cfg_ctl.sv
module strap_cfg_ctl
    import strap_cfg_pkg::*;
#(
    parameter int ADDR_W        = 5,
    parameter int MODE_W        = 3,
    parameter int SEED_W        = 11,
    parameter int REINIT_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic [MODE_W-1:0] strap_mode,
    input  logic              cfg_wr_en,
    input  logic [MODE_W-1:0] cfg_wr_data,
    input  logic              srst_req,
    input  logic              frame_vld,
    input  logic [ADDR_W-1:0] frame_addr,
    output logic              strap_done,
    output logic [ADDR_W-1:0] phy_addr,
    output logic [SEED_W-1:0] scram_seed,
    output logic [MODE_W-1:0] cfg_bits,
    output logic              soft_rst,
    output logic              addr_match
);
    localparam int FILL_W = SEED_W - ADDR_W;

    strap_cfg_capture #(.ADDR_W(ADDR_W), .MODE_W(MODE_W)) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_addr  (strap_addr),
        .strap_mode  (strap_mode),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .done        (strap_done),
        .addr        (phy_addr),
        .cfg         (cfg_bits)
    );

    strap_cfg_match #(.ADDR_W(ADDR_W)) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (strap_done),
        .own_addr   (phy_addr),
        .frame_vld  (frame_vld),
        .frame_addr (frame_addr),
        .hit        (addr_match)
    );

    strap_cfg_softrst #(.REINIT_CYCLES(REINIT_CYCLES)) u_softrst (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (strap_done),
        .req   (srst_req),
        .busy  (soft_rst)
    );

    // Seed: address in the low bits, filler above keeps it non-zero
    generate
        if (FILL_W > 0) begin : g_seed_fill
            assign scram_seed = {{FILL_W{SEED_FILL_BIT}}, phy_addr};
        end else begin : g_seed_trunc
            assign scram_seed = phy_addr[SEED_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/strap_cfg_ctl_chk.sv
module strap_cfg_ctl_chk #(
    parameter int ADDR_W        = 5,
    parameter int MODE_W        = 3,
    parameter int REINIT_CYCLES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] strap_addr,
    input logic              cfg_wr_en,
    input logic              frame_vld,
    input logic [ADDR_W-1:0] frame_addr,
    input logic              strap_done,
    input logic [ADDR_W-1:0] phy_addr,
    input logic [MODE_W-1:0] cfg_bits,
    input logic              soft_rst,
    input logic              addr_match
);
    int hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= 0;
        end else if (soft_rst) begin
            hi_cnt <= hi_cnt + 1;
        end else begin
            hi_cnt <= 0;
        end
    end

    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strap_done) |-> (phy_addr == $past(strap_addr)));

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_done && $past(strap_done)) |-> $stable(phy_addr));

    p_match_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        addr_match |-> ($past(frame_vld) && ($past(frame_addr) == phy_addr)));

    p_srst_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> (hi_cnt < REINIT_CYCLES));

    p_srst_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(soft_rst) |-> (hi_cnt == REINIT_CYCLES));

    p_cfg_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && !cfg_wr_en) |=> $stable(cfg_bits));
endmodule

bind strap_cfg_ctl strap_cfg_ctl_chk #(
    .ADDR_W(ADDR_W), .MODE_W(MODE_W), .REINIT_CYCLES(REINIT_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .cfg_wr_en(cfg_wr_en),
    .frame_vld(frame_vld), .frame_addr(frame_addr), .strap_done(strap_done),
    .phy_addr(phy_addr), .cfg_bits(cfg_bits), .soft_rst(soft_rst),
    .addr_match(addr_match)
);

// File: tb/strap_cfg_ctl_bench.sv
module strap_cfg_ctl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 5;
    localparam int MODE_W = 3;
    localparam int SEED_W = 11;
    localparam int REINIT = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] strap_addr;
    logic [MODE_W-1:0] strap_mode;
    logic              cfg_wr_en;
    logic [MODE_W-1:0] cfg_wr_data;
    logic              srst_req;
    logic              frame_vld;
    logic [ADDR_W-1:0] frame_addr;
    logic              strap_done;
    logic [ADDR_W-1:0] phy_addr;
    logic [SEED_W-1:0] scram_seed;
    logic [MODE_W-1:0] cfg_bits;
    logic              soft_rst;
    logic              addr_match;

    strap_cfg_ctl #(.ADDR_W(ADDR_W), .MODE_W(MODE_W), .SEED_W(SEED_W),
                    .REINIT_CYCLES(REINIT)) u_strap_cfg_ctl (
        .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .strap_mode(strap_mode),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .srst_req(srst_req),
        .frame_vld(frame_vld), .frame_addr(frame_addr), .strap_done(strap_done),
        .phy_addr(phy_addr), .scram_seed(scram_seed), .cfg_bits(cfg_bits),
        .soft_rst(soft_rst), .addr_match(addr_match)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int          cyc;
        int          sel;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] obs(int sel);
        case (sel)
            0: return 32'(phy_addr);
            1: return 32'(cfg_bits);
            2: return 32'(strap_done);
            3: return 32'(scram_seed);
            4: return 32'(addr_match);
            default: return 32'(soft_rst);
        endcase
    endfunction

    function automatic logic [31:0] seed_of(logic [ADDR_W-1:0] a);
        return 32'({{(SEED_W-ADDR_W){1'b1}}, a});
    endfunction

    task automatic expect_at(int dly, int sel, logic [31:0] v, string r);
        item_t it;
        it.cyc = cyc + dly;
        it.sel = sel;
        it.exp = v;
        it.req = r;
        q.push_back(it);
    endtask

    // Monitor: compares every item due in the current cycle
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].cyc <= cyc) begin
                n_checks++;
                if (q[i].cyc < cyc || obs(q[i].sel) !== q[i].exp) begin
                    n_fail++;
                    $display("FAIL %s sel=%0d cyc=%0d actual=%h expected=%h",
                             q[i].req, q[i].sel, cyc, obs(q[i].sel), q[i].exp);
                end
                q.delete(i);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_reset(string r);
        expect_at(1, 2, 0, r);
        expect_at(1, 0, 0, r);
        expect_at(1, 1, 0, r);
        expect_at(1, 5, 0, r);
        expect_at(1, 4, 0, r);
    endtask

    initial begin
        rst_n = 1'b0;
        strap_addr = 5'h13;
        strap_mode = 3'b101;
        cfg_wr_en = 1'b0;
        cfg_wr_data = '0;
        srst_req = 1'b0;
        frame_vld = 1'b0;
        frame_addr = '0;
        tick(2);
        expect_reset("R1");
        tick(2);
        // release with a write and a soft-reset request on the capture edge
        rst_n = 1'b1;
        cfg_wr_en = 1'b1;
        cfg_wr_data = 3'b010;
        srst_req = 1'b1;
        expect_at(1, 2, 1, "R2");
        expect_at(1, 0, 32'h13, "R2");
        expect_at(1, 1, 32'h5, "R2 write on capture edge");
        expect_at(1, 5, 0, "R7 request on capture edge");
        expect_at(1, 3, seed_of(5'h13), "R4");
        tick(1);
        cfg_wr_en = 1'b0;
        srst_req = 1'b0;
        strap_addr = 5'h0A;
        strap_mode = 3'b011;
        expect_at(2, 0, 32'h13, "R3 pins moved");
        expect_at(2, 1, 32'h5, "R3 pins moved");
        tick(2);
        frame_vld = 1'b1;
        frame_addr = 5'h13;
        expect_at(1, 4, 1, "R5 own address");
        tick(1);
        frame_addr = 5'h12;
        expect_at(1, 4, 0, "R5 other address");
        tick(1);
        frame_addr = 5'h00;
        expect_at(1, 4, 0, "R5 address zero");
        tick(1);
        frame_vld = 1'b0;
        frame_addr = 5'h13;
        expect_at(1, 4, 0, "R5 no frame");
        tick(1);
        cfg_wr_en = 1'b1;
        cfg_wr_data = 3'b110;
        expect_at(1, 1, 32'h6, "R6");
        tick(1);
        cfg_wr_en = 1'b0;
        srst_req = 1'b1;
        for (int k = 1; k <= REINIT; k++) expect_at(k, 5, 1, "R7 window");
        expect_at(REINIT + 1, 5, 0, "R7 self clear");
        expect_at(REINIT + 2, 0, 32'h13, "R8 address kept");
        expect_at(REINIT + 2, 1, 32'h6, "R8 config kept");
        tick(1);
        srst_req = 1'b0;
        tick(2);
        srst_req = 1'b1;   // while busy: must not extend
        tick(1);
        srst_req = 1'b0;
        tick(8);
        expect_at(1, 5, 0, "R7 no restart");
        tick(2);
        rst_n = 1'b0;
        expect_reset("R1 second reset");
        tick(2);
        strap_addr = 5'h00;
        strap_mode = 3'b011;
        rst_n = 1'b1;
        expect_at(1, 0, 0, "R3 recapture");
        expect_at(1, 1, 32'h3, "R3 recapture");
        expect_at(1, 3, seed_of(5'h00), "R4 zero address");
        tick(1);
        frame_vld = 1'b1;
        frame_addr = 5'h00;
        expect_at(1, 4, 1, "R5 zero own address");
        tick(1);
        frame_addr = 5'h1F;
        expect_at(1, 4, 0, "R5 mismatch");
        tick(1);
        frame_vld = 1'b0;
        tick(4);
        if (q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL queue actual=%0d expected=0 pending items", q.size());
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule